// File: doc/BRIEF.md
# Raster Slot and Line Counter

This block keeps the horizontal slot position and the vertical line number of a tile-based video display processor. Each cycle with `slot_tick` high advances the slot counter by one. In two places the count skips a range of values instead of running straight through. Partway through each horizontal sweep the line counter steps, and the line counter also skips a range near the end of each frame. Where those skips fall depends on the horizontal width select and on the 50 Hz / 60 Hz standard select.

Two state machines hold the position within the sweep.

The horizontal machine has three states:
- `HS_LEAD` runs from slot 0 up to the line step slot. It moves to `HS_TRAIL` on the tick that reaches that slot.
- `HS_TRAIL` moves to `HS_WRAP` on the skip.
- `HS_WRAP` returns to `HS_LEAD` when the slot wraps from 255 to 0.

The vertical machine also has three states:
- `VR_ACTIVE` covers the displayed lines. It moves to `VR_BLANK` on the step into the first blanked line.
- `VR_BLANK` moves to `VR_TOP` on the line skip.
- `VR_TOP` returns to `VR_ACTIVE` when the line wraps from 0x1FF to 0.

The block also produces a one-cycle strobe when the line advances, a one-cycle strobe at the frame count point, and an active-line flag for the rest of the video pipeline.

Top module: `raster_sweep_counter`

## Requirements
- R1: After reset, or while reset is held: slot = 0, line = 0, both strobes low, `line_active` high. The latched width is narrow and the latched standard is 60 Hz.
- R2: Each cycle with `slot_tick` high advances the slot by one, and slot 255 is followed by 0. With `slot_tick` low, slot and line hold.
- R3: With wide width latched, the slot after 182 is 229. With narrow width latched, the slot after 147 is 233.
- R4: The line advances on the tick that moves the slot to 165 (wide) or 132 (narrow). `line_adv` is high for exactly the cycle in which the new slot and line first show.
- R5: `wide_sel` (1 = wide) is sampled only on the tick that wraps the slot to 0, so a change governs the next sweep and never the current one.
- R6: With 60 Hz latched (`std50_sel` = 0), line 0xEA is followed by 0x1E5, giving 262 lines per frame.
- R7: With 50 Hz latched (`std50_sel` = 1), line 0x10A is followed by 0x1D2, giving 313 lines per frame.
- R8: `std50_sel` is sampled only on the line step that wraps the line to 0.
- R9: `frame_inc` pulses for one cycle, together with `line_adv`, when the line becomes 232 (60 Hz) or 248 (50 Hz). It does not pulse at any other time.
- R10: `line_active` is high when the line is below 224 (60 Hz) or below 240 (50 Hz), and also on line 0x1FF. It is low otherwise.
- R11: The line is 9 bits wide, and line 0x1FF is followed by 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | Advance by one slot this cycle |
| wide_sel | input | 1 | 1 = wide horizontal mode, 0 = narrow |
| std50_sel | input | 1 | 1 = 50 Hz line count, 0 = 60 Hz |
| h_slot | output | 8 | Current horizontal slot |
| v_line | output | 9 | Current line number |
| line_adv | output | 1 | One-cycle strobe when the line changes |
| frame_inc | output | 1 | One-cycle strobe at the frame count line |
| line_active | output | 1 | Current line is timed as an active line |

## Verification
The hardest situations to reach are the line skips and the standard switch, because they only occur hundreds of lines after reset.

To reach them, the stimulus holds `slot_tick` high and walks through the rest of a 60 Hz frame, a complete 50 Hz frame and a complete 60 Hz frame. It flips `std50_sel` in mid-frame so that the latch point is exercised. On every line step, the bench compares each new line, frame strobe and active flag against its own model of the sequence, and it counts the lines in each complete frame.

A width change made in mid-sweep is also checked, in both directions, to confirm it waits for the slot wrap.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int SLOT_BITS = 8;
    localparam int LINE_BITS = 9;

    // horizontal landmarks
    localparam int WIDE_LINE_STEP   = 165;
    localparam int NARROW_LINE_STEP = 132;
    localparam int WIDE_SKIP_FROM   = 182;
    localparam int WIDE_SKIP_TO     = 229;
    localparam int NARROW_SKIP_FROM = 147;
    localparam int NARROW_SKIP_TO   = 233;

    // vertical landmarks
    localparam int BLANK_START_60 = 224;
    localparam int BLANK_START_50 = 240;
    localparam int JUMP_FROM_60   = 'h0EA;
    localparam int JUMP_TO_60     = 'h1E5;
    localparam int JUMP_FROM_50   = 'h10A;
    localparam int JUMP_TO_50     = 'h1D2;
    localparam int FRAME_OFFSET   = 8;

    typedef enum logic [1:0] {
        HS_LEAD  = 2'd0,
        HS_TRAIL = 2'd1,
        HS_WRAP  = 2'd2
    } hphase_t;

    typedef enum logic [1:0] {
        VR_ACTIVE = 2'd0,
        VR_BLANK  = 2'd1,
        VR_TOP    = 2'd2
    } vregion_t;

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
    parameter int SLOT_W = raster_pkg::SLOT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wide_sel,
    output logic [SLOT_W-1:0] slot_o,
    output logic              line_step_o
);
    import raster_pkg::*;

    localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};
    localparam logic [SLOT_W-1:0] W_STEP   = SLOT_W'(WIDE_LINE_STEP);
    localparam logic [SLOT_W-1:0] N_STEP   = SLOT_W'(NARROW_LINE_STEP);
    localparam logic [SLOT_W-1:0] W_FROM   = SLOT_W'(WIDE_SKIP_FROM);
    localparam logic [SLOT_W-1:0] W_TO     = SLOT_W'(WIDE_SKIP_TO);
    localparam logic [SLOT_W-1:0] N_FROM   = SLOT_W'(NARROW_SKIP_FROM);
    localparam logic [SLOT_W-1:0] N_TO     = SLOT_W'(NARROW_SKIP_TO);

    hphase_t           phase_q, phase_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              wide_q;
    logic [SLOT_W-1:0] step_at, skip_from, skip_to;
    logic              wrap_now;

    assign step_at   = wide_q ? W_STEP : N_STEP;
    assign skip_from = wide_q ? W_FROM : N_FROM;
    assign skip_to   = wide_q ? W_TO   : N_TO;
    assign wrap_now  = tick && (phase_q == HS_WRAP) && (slot_q == SLOT_MAX);

    // next state and outputs
    always_comb begin
        phase_d     = phase_q;
        slot_d      = slot_q;
        line_step_o = 1'b0;
        if (tick) begin
            slot_d = slot_q + SLOT_ONE;
            unique case (phase_q)
                HS_LEAD: begin
                    if (slot_d == step_at) begin
                        line_step_o = 1'b1;
                        phase_d     = HS_TRAIL;
                    end
                end
                HS_TRAIL: begin
                    if (slot_q == skip_from) begin
                        slot_d  = skip_to;
                        phase_d = HS_WRAP;
                    end
                end
                HS_WRAP: begin
                    if (slot_q == SLOT_MAX) phase_d = HS_LEAD;
                end
                default: phase_d = HS_LEAD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= HS_LEAD;
            slot_q  <= '0;
            wide_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            slot_q  <= slot_d;
            if (wrap_now) wide_q <= wide_sel;
        end
    end

    assign slot_o = slot_q;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slot_o));
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && slot_o == SLOT_MAX) |=> (slot_o == '0));
    assert_wide_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wide_q && slot_o == W_FROM) |=> (slot_o == W_TO));
    assert_narrow_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wide_q && slot_o == N_FROM) |=> (slot_o == N_TO));
    assert_width_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o != '0) |-> $stable(wide_q));

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
    parameter int LINE_W = raster_pkg::LINE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              std50_sel,
    output logic [LINE_W-1:0] line_o,
    output logic              line_adv_o,
    output logic              frame_inc_o,
    output logic              active_o
);
    import raster_pkg::*;

    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};
    localparam logic [LINE_W-1:0] B60  = LINE_W'(BLANK_START_60);
    localparam logic [LINE_W-1:0] B50  = LINE_W'(BLANK_START_50);
    localparam logic [LINE_W-1:0] JF60 = LINE_W'(JUMP_FROM_60);
    localparam logic [LINE_W-1:0] JT60 = LINE_W'(JUMP_TO_60);
    localparam logic [LINE_W-1:0] JF50 = LINE_W'(JUMP_FROM_50);
    localparam logic [LINE_W-1:0] JT50 = LINE_W'(JUMP_TO_50);
    localparam logic [LINE_W-1:0] FOFS = LINE_W'(FRAME_OFFSET);

    vregion_t          reg_q, reg_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic              std_q, adv_q, frame_q;
    logic [LINE_W-1:0] blank_at, jump_from, jump_to, frame_at;

    assign blank_at  = std_q ? B50  : B60;
    assign jump_from = std_q ? JF50 : JF60;
    assign jump_to   = std_q ? JT50 : JT60;
    assign frame_at  = blank_at + FOFS;

    // next state
    always_comb begin
        reg_d  = reg_q;
        line_d = line_q;
        if (step) begin
            line_d = line_q + LINE_ONE;
            unique case (reg_q)
                VR_ACTIVE: begin
                    if (line_d == blank_at) reg_d = VR_BLANK;
                end
                VR_BLANK: begin
                    if (line_q == jump_from) begin
                        line_d = jump_to;
                        reg_d  = VR_TOP;
                    end
                end
                VR_TOP: begin
                    if (line_q == LINE_MAX) reg_d = VR_ACTIVE;
                end
                default: reg_d = VR_ACTIVE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q   <= VR_ACTIVE;
            line_q  <= '0;
            std_q   <= 1'b0;
            adv_q   <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            reg_q   <= reg_d;
            line_q  <= line_d;
            adv_q   <= step;
            frame_q <= step && (reg_q == VR_BLANK) && (line_d == frame_at);
            if (step && reg_q == VR_TOP && line_q == LINE_MAX) std_q <= std50_sel;
        end
    end

    // outputs
    always_comb begin
        line_o      = line_q;
        line_adv_o  = adv_q;
        frame_inc_o = frame_q;
        active_o    = (reg_q == VR_ACTIVE) || (line_q == LINE_MAX);
    end

    assert_line_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (line_o != $past(line_o)));
    assert_gap60_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !std_q |-> !(line_o > JF60 && line_o < JT60));
    assert_gap50_R7: assert property (@(posedge clk) disable iff (!rst_n)
        std_q |-> !(line_o > JF50 && line_o < JT50));
    assert_std_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != '0) |-> $stable(std_q));
    assert_frame_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_inc_o |-> (line_o == frame_at && line_adv_o));
    assert_blank_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o == blank_at) |-> !active_o);

endmodule

// File: rtl/raster_sweep_counter.sv
module raster_sweep_counter #(
    parameter int SLOT_W = raster_pkg::SLOT_BITS,
    parameter int LINE_W = raster_pkg::LINE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_tick,
    input  logic              wide_sel,
    input  logic              std50_sel,
    output logic [SLOT_W-1:0] h_slot,
    output logic [LINE_W-1:0] v_line,
    output logic              line_adv,
    output logic              frame_inc,
    output logic              line_active
);
    import raster_pkg::*;

    localparam logic [SLOT_W-1:0] W_STEP = SLOT_W'(WIDE_LINE_STEP);
    localparam logic [SLOT_W-1:0] N_STEP = SLOT_W'(NARROW_LINE_STEP);

    logic line_step;

    raster_hcount #(.SLOT_W(SLOT_W)) u_hcount (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (slot_tick),
        .wide_sel    (wide_sel),
        .slot_o      (h_slot),
        .line_step_o (line_step)
    );

    raster_vcount #(.LINE_W(LINE_W)) u_vcount (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (line_step),
        .std50_sel   (std50_sel),
        .line_o      (v_line),
        .line_adv_o  (line_adv),
        .frame_inc_o (frame_inc),
        .active_o    (line_active)
    );

    assert_adv_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv |-> (h_slot == W_STEP || h_slot == N_STEP));
    assert_adv_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv |=> !line_adv);

endmodule

// File: tb/raster_sweep_counter_test.sv
module raster_sweep_counter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_tick = 1'b0;
    logic       wide_sel = 1'b0;
    logic       std50_sel = 1'b0;
    logic [7:0] h_slot;
    logic [8:0] v_line;
    logic       line_adv, frame_inc, line_active;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    raster_sweep_counter uut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .wide_sel(wide_sel),
        .std50_sel(std50_sel), .h_slot(h_slot), .v_line(v_line),
        .line_adv(line_adv), .frame_inc(frame_inc), .line_active(line_active)
    );

    // ticks, expected slot, expected line, expected line_adv, from reset (narrow, 60 Hz)
    localparam int VTAB [7][4] = '{
        '{131, 131, 0, 0},   // R2 plain count
        '{1,   132, 1, 1},   // R4 narrow line step
        '{1,   133, 1, 0},   // R4 strobe lasts one cycle
        '{14,  147, 1, 0},   // R2
        '{1,   233, 1, 0},   // R3 narrow skip
        '{22,  255, 1, 0},   // R2
        '{1,   0,   1, 0}    // R2 wrap
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // called at a negedge; leaves at a negedge after n advancing edges
    task automatic run(input int n);
        slot_tick = 1'b1;
        repeat (n) @(negedge clk);
        slot_tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int prev, nx, lines, wraps, std_m, blank;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "slot", h_slot, 0);
        chk("R1", "line", v_line, 0);
        chk("R1", "line_adv", line_adv, 0);
        chk("R1", "frame_inc", frame_inc, 0);
        chk("R1", "active", line_active, 1);

        for (int i = 0; i < 7; i++) begin
            run(VTAB[i][0]);
            chk("R2/R3/R4 vec", "slot", h_slot, VTAB[i][1]);
            chk("R2/R3/R4 vec", "line", v_line, VTAB[i][2]);
            chk("R4 vec", "line_adv", line_adv, VTAB[i][3]);
        end

        // R2 no tick: hold
        repeat (5) @(negedge clk);
        chk("R2", "hold slot", h_slot, 0);
        chk("R2", "hold line", v_line, 1);

        // R5 width change in mid-sweep waits for wrap
        wide_sel = 1'b1;
        run(132);
        chk("R5", "still narrow step slot", h_slot, 132);
        chk("R5", "still narrow line", v_line, 2);
        chk("R5", "line_adv", line_adv, 1);
        run(39);
        chk("R5", "wrap slot", h_slot, 0);
        run(164);
        chk("R5", "wide no step yet", v_line, 2);
        run(1);
        chk("R4", "wide step slot", h_slot, 165);
        chk("R4", "wide step line", v_line, 3);
        chk("R4", "wide line_adv", line_adv, 1);
        run(17);
        chk("R3", "before wide skip", h_slot, 182);
        run(1);
        chk("R3", "wide skip", h_slot, 229);
        run(26);
        chk("R2", "wide top", h_slot, 255);
        wide_sel = 1'b0;
        run(1);
        chk("R2", "wide wrap", h_slot, 0);
        run(132);
        chk("R5", "back to narrow line", v_line, 4);
        chk("R5", "back to narrow adv", line_adv, 1);

        // frame walk: rest of 60 Hz frame, full 50 Hz, full 60 Hz
        std50_sel = 1'b1;
        prev = 4; lines = 0; wraps = 0; std_m = 0;
        slot_tick = 1'b1;
        while (wraps < 3) begin
            @(negedge clk);
            if (line_adv) begin
                nx = (prev + 1) & 511;
                tag = "R4";
                if (std_m == 0 && prev == 'h0EA) begin nx = 'h1E5; tag = "R6"; end
                if (std_m == 1 && prev == 'h10A) begin nx = 'h1D2; tag = "R7"; end
                if (prev == 511) tag = "R11";
                lines++;
                if (nx == 0) begin
                    if (wraps > 0) chk(std_m ? "R7" : "R6", "lines per frame", lines, std_m ? 313 : 262);
                    std_m = std50_sel;   // R8 latched at wrap to line 0
                    wraps++;
                    lines = 0;
                    std50_sel = 1'b0;    // flip mid-frame; must not act until next wrap
                end
                blank = std_m ? 240 : 224;
                chk(tag, "next line", v_line, nx);
                chk("R9", "frame_inc", frame_inc, (nx == blank + 8) ? 1 : 0);
                chk("R10", "active", line_active, (nx < blank || nx == 511) ? 1 : 0);
                prev = nx;
            end else if (frame_inc) begin
                chk("R9", "frame_inc without line step", 1, 0);
            end
        end
        slot_tick = 1'b0;

        // R1 reset in mid-run
        run(50);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "slot in reset", h_slot, 0);
        chk("R1", "line in reset", v_line, 0);
        chk("R1", "active in reset", line_active, 1);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule